// File: doc/BRIEF.md
# MATS+ March Self-Test Controller

This block runs a three-element march test on a single-port RAM with a one-bit data path and a depth set by a parameter. A pulse on `start` launches the test. The controller then drives address, write-enable, write-data and read-enable toward the memory and checks every value it reads back against the value a fault-free cell would hold.

The three elements always run in the same order:

- The first element writes 0 to every cell, ascending.
- The second element walks upward from the lowest address. At each cell it reads an expected 0 and then writes 1.
- The third element walks downward from the highest address. At each cell it reads an expected 1 and then writes 0.

Every operation on a cell finishes before the address moves on. A test therefore costs 5·N memory cycles, plus an optional idle pause before each read element. The pause lets data-retention faults show up, and its length in clock cycles is a parameter.

On the first mismatch the controller records four things: a fail flag, the cell address, the element that saw it (1 or 2) and the bit it expected. The `stop_on_fail` input then selects one of two behaviours. Either the test ends at once, or it runs to the end while the first record is held.

Top module: `mats_bist`

## Requirements
- R1: After `start`, the first element issues one write of 0 per cycle at addresses 0, 1, …, DEPTH-1 in that order.
- R2: The second element visits addresses 0 to DEPTH-1 in ascending order. At each address it issues a read, and in the next cycle a write of 1 to the same address.
- R3: The third element visits addresses DEPTH-1 down to 0. At each address it issues a read, and in the next cycle a write of 0 to the same address.
- R4: PAUSE_CYCLES idle cycles, with no read and no write, separate the first element from the second and the second from the third. A full run keeps `busy` high for exactly 5·DEPTH + 2·PAUSE_CYCLES cycles and issues exactly 5·DEPTH memory operations.
- R5: Read data is taken one cycle after the read is issued. A cell that returns 1 where 0 is expected is reported with `fail`=1, `fail_elem`=1, `fail_exp`=0 and `fail_addr` set to that cell.
- R6: A cell that returns 0 where 1 is expected is reported with `fail`=1, `fail_elem`=2, `fail_exp`=1 and `fail_addr` set to that cell.
- R7: Only the first mismatch of a run is recorded. Later mismatches in the same run leave `fail_addr`, `fail_elem` and `fail_exp` unchanged.
- R8: With `stop_on_fail`=1, the test ends in the cycle after the write that follows the failing read. `busy` then lasts DEPTH + PAUSE_CYCLES + 2·(a+1) cycles for a failure at cell a in element 1, and 5·DEPTH + 2·PAUSE_CYCLES − 2·a cycles for a failure at cell a in element 2. With `stop_on_fail`=0 the run length is that of R4.
- R9: `busy` rises in the cycle after `start` is sampled and stays high through the last memory operation. `done` is high for exactly one cycle, while `busy` is low, and the failure record is final in that cycle.
- R10: A `start` pulse while `busy` is high has no effect on the run. A `start` taken while idle clears the previous failure record.
- R11: While `rst` is high, and right after it is released, `busy`, `done`, `fail`, `mem_we` and `mem_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test; sampled only while idle |
| stop_on_fail | input | 1 | 1: end the test at the first mismatch |
| mem_addr | output | $clog2(DEPTH) | Address toward the RAM |
| mem_we | output | 1 | Write enable toward the RAM |
| mem_wdata | output | 1 | Write data toward the RAM |
| mem_re | output | 1 | Read enable toward the RAM |
| mem_rdata | input | 1 | Registered read data, valid one cycle after `mem_re` |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | A mismatch was seen in this or the last run |
| fail_addr | output | $clog2(DEPTH) | Address of the first mismatch |
| fail_elem | output | 2 | Element of the first mismatch (1 or 2) |
| fail_exp | output | 1 | Bit expected at the first mismatch |

## Verification
Each read has a fixed schedule. The read is issued in one cycle, and its data is checked during the write cycle that follows. The failure record is registered at the edge that ends that write cycle, which is the same edge that raises `done` when the test stops early. The bench samples every output at the falling edge. It counts busy cycles from the first falling edge after `start` up to the one where `done` is seen, and compares that count and the failure record against the cycle formulas of R4 and R8. A per-cycle log of memory operations, taken at the falling edges, is compared against the address orders of R1 to R3 and the pause gaps of R4.

// File: rtl/mats_pkg.sv
package mats_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,      // element 0: write 0, ascending
    ST_GAP_A,     // retention pause before element 1
    ST_UP_RD,     // element 1: read, expect 0
    ST_UP_WR,     // element 1: write 1
    ST_GAP_B,     // retention pause before element 2
    ST_DN_RD,     // element 2: read, expect 1
    ST_DN_WR      // element 2: write 0
  } seq_state_t;

  localparam logic [1:0] ELEM_UP = 2'd1;
  localparam logic [1:0] ELEM_DN = 2'd2;

endpackage

// File: rtl/mats_addr_gen.sv
module mats_addr_gen #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_lo,
  input  logic          load_hi,
  input  logic          step,
  input  logic          dn,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load_lo) begin
      addr <= '0;
    end else if (load_hi) begin
      addr <= LAST;
    end else if (step) begin
      addr <= dn ? addr - AW'(1) : addr + AW'(1);
    end
  end

  assign at_end = dn ? (addr == '0) : (addr == LAST);

  p_addr_range_r1: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST)
    else $error("address beyond last cell");

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !dn && !load_lo && !load_hi) |=> addr == $past(addr) + AW'(1))
    else $error("ascending step broken");

  p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
    (step && dn && !load_lo && !load_hi) |=> addr == $past(addr) - AW'(1))
    else $error("descending step broken");

endmodule

// File: rtl/mats_pause_timer.sv
module mats_pause_timer #(
  parameter int unsigned PAUSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic run,
  output logic last
);

  generate
    if (PAUSE_CYCLES > 0) begin : g_timer
      localparam int unsigned CW = (PAUSE_CYCLES > 1) ? $clog2(PAUSE_CYCLES) : 1;
      localparam logic [CW-1:0] LOAD = CW'(PAUSE_CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (arm) begin
          cnt <= LOAD;
        end else if (run && cnt != '0) begin
          cnt <= cnt - CW'(1);
        end
      end

      assign last = (cnt == '0);

      p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD)
        else $error("pause counter out of range");

      p_cnt_down_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !arm && cnt != '0) |=> cnt == $past(cnt) - CW'(1))
        else $error("pause counter skipped");
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst ^ arm ^ run;
      assign last = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/mats_compare.sv
module mats_compare #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          chk,
  input  logic          exp_bit,
  input  logic          rdata,
  input  logic [AW-1:0] cur_addr,
  input  logic [1:0]    cur_elem,
  output logic          miss,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_elem,
  output logic          fail_exp
);

  assign miss = chk && (rdata != exp_bit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= 2'd0;
      fail_exp  <= 1'b0;
    end else if (miss && !fail) begin
      fail      <= 1'b1;
      fail_addr <= cur_addr;
      fail_elem <= cur_elem;
      fail_exp  <= exp_bit;
    end
  end

  p_first_only_r7: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_elem) && $stable(fail_exp)))
    else $error("failure record overwritten");

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (miss && !fail && !clr) |=> fail)
    else $error("mismatch not recorded");

endmodule

// File: rtl/mats_bist.sv
module mats_bist
  import mats_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned PAUSE_CYCLES = 20_000_000,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop_on_fail,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_wdata,
  output logic          mem_re,
  input  logic          mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_elem,
  output logic          fail_exp
);

  localparam bit HAS_PAUSE = (PAUSE_CYCLES > 0);

  seq_state_t state, state_n;
  logic busy_q, done_q;
  logic load_lo, load_hi, step, dn, at_end;
  logic arm, run, pause_last;
  logic clr, chk, exp_bit, miss, fin;
  logic [1:0] cur_elem;
  logic [AW-1:0] addr;

  mats_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst(rst), .load_lo(load_lo), .load_hi(load_hi),
    .step(step), .dn(dn), .addr(addr), .at_end(at_end)
  );

  mats_pause_timer #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_pause (
    .clk(clk), .rst(rst), .arm(arm), .run(run), .last(pause_last)
  );

  mats_compare #(.AW(AW)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .chk(chk), .exp_bit(exp_bit),
    .rdata(mem_rdata), .cur_addr(addr), .cur_elem(cur_elem),
    .miss(miss), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem), .fail_exp(fail_exp)
  );

  // data for a read arrives during the write cycle of the same cell
  assign dn       = (state == ST_DN_RD) || (state == ST_DN_WR);
  assign run      = (state == ST_GAP_A) || (state == ST_GAP_B);
  assign chk      = (state == ST_UP_WR) || (state == ST_DN_WR);
  assign exp_bit  = (state == ST_DN_WR);
  assign cur_elem = (state == ST_DN_WR) ? ELEM_DN : ELEM_UP;

  always_comb begin
    state_n = state;
    load_lo = 1'b0;
    load_hi = 1'b0;
    step    = 1'b0;
    arm     = 1'b0;
    clr     = 1'b0;
    fin     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_FILL;
          load_lo = 1'b1;
          clr     = 1'b1;
        end
      end
      ST_FILL: begin
        if (at_end) begin
          load_lo = 1'b1;
          arm     = HAS_PAUSE;
          state_n = HAS_PAUSE ? ST_GAP_A : ST_UP_RD;
        end else begin
          step = 1'b1;
        end
      end
      ST_GAP_A: if (pause_last) state_n = ST_UP_RD;
      ST_UP_RD: state_n = ST_UP_WR;
      ST_UP_WR: begin
        if (stop_on_fail && miss) begin
          fin = 1'b1;
        end else if (at_end) begin
          load_hi = 1'b1;
          arm     = HAS_PAUSE;
          state_n = HAS_PAUSE ? ST_GAP_B : ST_DN_RD;
        end else begin
          step    = 1'b1;
          state_n = ST_UP_RD;
        end
      end
      ST_GAP_B: if (pause_last) state_n = ST_DN_RD;
      ST_DN_RD: state_n = ST_DN_WR;
      ST_DN_WR: begin
        if ((stop_on_fail && miss) || at_end) begin
          fin = 1'b1;
        end else begin
          step    = 1'b1;
          state_n = ST_DN_RD;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (fin) state_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= state_n;
      busy_q <= (state_n != ST_IDLE);
      done_q <= fin;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign mem_addr  = addr;
  assign mem_we    = (state == ST_FILL) || (state == ST_UP_WR) || (state == ST_DN_WR);
  assign mem_wdata = (state == ST_UP_WR);
  assign mem_re    = (state == ST_UP_RD) || (state == ST_DN_RD);

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (mem_we && mem_addr == $past(mem_addr)))
    else $error("read not followed by write of same cell");

  p_we_re_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re))
    else $error("read and write together");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done wider than one cycle");

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy)
    else $error("done while busy");

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done)
    else $error("busy dropped without done");

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (miss && stop_on_fail) |=> (done && fail))
    else $error("stop on fail ignored");

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_we || mem_re))
    else $error("memory access while idle");

endmodule

// File: tb/tb_mats_bist.sv
module tb_mats_bist;

  localparam int N  = 16;
  localparam int P  = 4;
  localparam int AW = 4;

  typedef struct packed {
    logic          f1;
    logic [AW-1:0] a1;
    logic          f2;
    logic [AW-1:0] a2;
    logic          sv;    // stuck value of the faulty cells
    logic          stop;
    logic          ef;    // expected fail
    logic [1:0]    el;    // expected element
    logic [AW-1:0] ea;    // expected address
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0 },  // clean
    '{1'b1, 4'd5,  1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 2'd1, 4'd5 },  // one cell reads 1
    '{1'b1, 4'd5,  1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 2'd2, 4'd5 },  // one cell reads 0
    '{1'b1, 4'd3,  1'b1, 4'd9, 1'b1, 1'b1, 1'b1, 2'd1, 4'd3 },  // two read 1, stop
    '{1'b1, 4'd3,  1'b1, 4'd9, 1'b0, 1'b0, 1'b1, 2'd2, 4'd9 },  // two read 0, continue
    '{1'b1, 4'd0,  1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 2'd2, 4'd0 },  // last cell of element 2, stop
    '{1'b1, 4'd15, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 2'd1, 4'd15},  // last cell of element 1, stop
    '{1'b0, 4'd0,  1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd0 }   // clean after a failure
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic stop_on_fail = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_wdata, mem_re;
  logic mem_rdata = 1'b0;
  logic busy, done, fail, fail_exp;
  logic [AW-1:0] fail_addr;
  logic [1:0] fail_elem;

  always #2.5 clk = ~clk;

  mats_bist #(.DEPTH(N), .PAUSE_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .start(start), .stop_on_fail(stop_on_fail),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
    .fail_exp(fail_exp)
  );

  // memory model with stuck cells
  logic cells [N];
  logic f1 = 1'b0, f2 = 1'b0, sv = 1'b0;
  logic [AW-1:0] a1 = '0, a2 = '0;

  function automatic logic stuck(input logic [AW-1:0] a);
    return (f1 && a == a1) || (f2 && a == a2);
  endfunction

  always @(posedge clk) begin
    if (mem_we && !stuck(mem_addr)) cells[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= stuck(mem_addr) ? sv : cells[mem_addr];
  end

  // operation log
  int cyc = 0;
  int n_ops = 0;
  bit rec_on = 1'b0;
  logic          op_we  [128];
  logic [AW-1:0] op_addr[128];
  logic          op_d   [128];
  int            op_cyc [128];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rec_on && (mem_we || mem_re) && n_ops < 128) begin
      op_we[n_ops]   <= mem_we;
      op_addr[n_ops] <= mem_addr;
      op_d[n_ops]    <= mem_wdata;
      op_cyc[n_ops]  <= cyc;
      n_ops          <= n_ops + 1;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int  bcyc;
  bit  done_seen;
  logic done_busy;

  task automatic launch(input logic stp, input int poke_at);
    stop_on_fail = stp;
    @(negedge clk);
    n_ops  = 0;
    rec_on = 1'b1;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcyc = 0;
    done_seen = 1'b0;
    done_busy = 1'b0;
    for (int k = 0; k < 2000 && !done_seen; k++) begin
      if (done) begin
        done_seen = 1'b1;
        done_busy = busy;
      end else begin
        if (busy) bcyc++;
        start = (k == poke_at);
        @(negedge clk);
      end
    end
    start = 1'b0;
    rec_on = 1'b0;
  endtask

  function automatic int exp_cycles(input vec_t v);
    if (!v.ef || !v.stop) return 5*N + 2*P;
    if (v.el == 2'd1) return N + P + 2*(int'(v.ea) + 1);
    return 5*N + 2*P - 2*int'(v.ea);
  endfunction

  task automatic check_sequence();
    int bad1 = 0, bad2 = 0, bad3 = 0;
    for (int k = 0; k < N; k++)
      if (!op_we[k] || op_addr[k] != AW'(k) || op_d[k] != 1'b0) bad1++;
    for (int j = 0; j < 2*N; j++) begin
      int c = j / 2;
      int k = N + j;
      if (j % 2 == 0) begin
        if (op_we[k] || op_addr[k] != AW'(c)) bad2++;
      end else begin
        if (!op_we[k] || op_addr[k] != AW'(c) || op_d[k] != 1'b1 ||
            op_cyc[k] != op_cyc[k-1] + 1) bad2++;
      end
    end
    for (int j = 0; j < 2*N; j++) begin
      int c = N - 1 - j / 2;
      int k = 3*N + j;
      if (j % 2 == 0) begin
        if (op_we[k] || op_addr[k] != AW'(c)) bad3++;
      end else begin
        if (!op_we[k] || op_addr[k] != AW'(c) || op_d[k] != 1'b0 ||
            op_cyc[k] != op_cyc[k-1] + 1) bad3++;
      end
    end
    check("R1", "fill order mismatches", bad1, 0);
    check("R2", "ascending element mismatches", bad2, 0);
    check("R3", "descending element mismatches", bad3, 0);
    check("R4", "operation count", n_ops, 5*N);
    check("R4", "gap before element 1", op_cyc[N] - op_cyc[N-1], P + 1);
    check("R4", "gap before element 2", op_cyc[3*N] - op_cyc[3*N-1], P + 1);
  endtask

  // watchdog
  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "busy in reset", busy, 0);
    check("R11", "done in reset", done, 0);
    check("R11", "fail in reset", fail, 0);
    check("R11", "access in reset", mem_we | mem_re, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "busy after reset", busy, 0);
    check("R11", "fail after reset", fail, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string rq = (!v.ef) ? "R10" : (v.el == 2'd1 ? "R5" : "R6");
      string rl = v.stop ? "R8" : "R4";
      f1 = v.f1; a1 = v.a1; f2 = v.f2; a2 = v.a2; sv = v.sv;
      launch(v.stop, -1);
      check("R9", "done seen", done_seen, 1);
      check("R9", "busy with done", done_busy, 0);
      check(rl, "busy cycles", bcyc, exp_cycles(v));
      check(rq, "fail flag", fail, v.ef);
      if (v.ef) begin
        check(v.f2 ? "R7" : rq, "fail address", fail_addr, v.ea);
        check(rq, "fail element", fail_elem, v.el);
        check(rq, "fail expected bit", fail_exp, (v.el == 2'd2));
      end
      @(negedge clk);
      check("R9", "done width", done, 0);
      if (i == 0) check_sequence();
    end

    // R10: start while busy has no effect
    f1 = 1'b0; f2 = 1'b0;
    launch(1'b0, 20);
    check("R10", "busy cycles with extra start", bcyc, 5*N + 2*P);
    begin
      int busy_after = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (busy) busy_after++;
      end
      check("R10", "no second run", busy_after, 0);
    end

    // R11: reset in the middle of a run
    stop_on_fail = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "busy after mid-run reset", busy, 0);
    check("R11", "access after mid-run reset", mem_we | mem_re, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule